// File: doc/BRIEF.md
# Low-Power Mode and Reset Controller

This block sequences the operating states of a small 8-bit microcontroller core: normal run, idle (CPU clock halted while peripherals keep running) and power-down (oscillator stopped, everything frozen). Software enters the low-power states by pulsing an idle request or a power-down request. If both arrive together, power-down wins. Idle is left by any enabled interrupt or by a hardware reset. Power-down is left only by a hardware reset, which restarts the oscillator and holds the internal reset for a stabilisation count.

The reset pin is filtered. The internal reset asserts only after the pin has been sampled high for two machine cycles in a row (24 oscillator clocks by default). When the reset pin rises while the core is idle, the CPU clock comes back at once, because the core runs on until the qualified reset takes over. During that window the controller raises a RAM-access inhibit. Port accesses are not blocked. When a lock bit is set, the external-access pin level is sampled on every clock of the internal reset and held after it. With the lock bit clear, the flag follows the pin. The oscillator itself is modelled only as an enable output.

Top module: `lowpwr_rst_ctrl`

## Requirements
- R1: `intReset` rises after the 24th consecutive clock edge at which `rstPin` is sampled high (default parameters), and a high pulse of 23 samples causes no reset. Outside the stabilisation phase, `intReset` is low one edge after `rstPin` is sampled low.
- R2: In run mode with no reset active, a pulse on `idleReq` alone gives `cpuClkEn`=0, `periphClkEn`=1 and `oscEn`=1 after the next edge. Idle persists while `irqVec` is all zero.
- R3: In idle, any nonzero `irqVec` sampled at an edge restores `cpuClkEn`=1 after that edge.
- R4: In run mode, a pulse on `pdReq` gives `cpuClkEn`=`periphClkEn`=`oscEn`=0 after the next edge. When `idleReq` and `pdReq` are high in the same cycle, power-down is entered.
- R5: In power-down, `irqVec` has no effect: `oscEn` stays 0 while `rstPin` is low.
- R6: In power-down, one high sample of `rstPin` sets `oscEn`=1 and `intReset`=1 after that edge. `intReset` stays high for exactly STAB_CYCLES cycles even if the pin falls earlier, and `cpuClkEn` and `periphClkEn` stay 0 during that time. Run mode then follows with all enables high. If the pin is still high at that point, the reset is held until the pin is sampled low.
- R7: A rising `rstPin` in idle sets `cpuClkEn`=1 and `ramInhibit`=1 after the first high sample. `ramInhibit` stays 1 until `intReset` asserts and is 0 from then on. In all other situations `ramInhibit` is 0.
- R8: With `lockBit`=1, `extAccessLatched` holds the `extAccessPin` value sampled at the last edge at which `intReset` was high, and ignores later pin changes. With `lockBit`=0 it equals `extAccessPin`.
- R9: While `intReset` is high, `idleReq` and `pdReq` are ignored: `oscEn` and `cpuClkEn` stay 1.
- R10: A reset pulse in idle that is too short to qualify returns the core to run mode (`cpuClkEn`=1, `ramInhibit`=0) one edge after the pin is sampled low, without asserting `intReset`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator-domain clock |
| rstPin | input | 1 | External reset pin, active high |
| idleReq | input | 1 | Software idle request pulse |
| pdReq | input | 1 | Software power-down request pulse |
| irqVec | input | IRQ_W | Enabled interrupt requests |
| extAccessPin | input | 1 | External-access pin level |
| lockBit | input | 1 | Lock bit 1; enables latching of the external-access level |
| cpuClkEn | output | 1 | CPU clock enable |
| periphClkEn | output | 1 | Peripheral clock enable |
| oscEn | output | 1 | Oscillator enable |
| intReset | output | 1 | Qualified internal reset |
| ramInhibit | output | 1 | Blocks RAM writes during the reset-out-of-idle window |
| extAccessLatched | output | 1 | External-access flag seen by the core |

## Verification
The hardest state to reach is the race between the reset qualifier and the exit from idle. The stimulus has to enter idle first, then raise the pin and hold it for an exact number of edges, so that the inhibit window can be checked on every cycle up to and including the edge where the reset takes over. The same exact counting is used for the 23- and 24-sample boundary and for the stabilisation hold after power-down, both with an early pin release and with a late one. Random runs of idle, power-down and interrupt traffic are checked against a bench mode model, and each power-down they reach is left through the wake sequence.

// File: rtl/lpr_pkg.sv
package lpr_pkg;

  typedef enum logic [2:0] {
    MODE_RUN    = 3'd0,
    MODE_IDLE   = 3'd1,
    MODE_RSTWIN = 3'd2,
    MODE_PDOWN  = 3'd3,
    MODE_STAB   = 3'd4
  } lpr_mode_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic qualHold;  // oscillator stopped: qualifier cannot count
    logic stabRun;   // stabilisation counter runs
    logic forceRst;  // hold internal reset during stabilisation
  } lpr_strobe_t;

endpackage

// File: rtl/lpr_datapath.sv
module lpr_datapath
  import lpr_pkg::*;
#(
  parameter int QUAL_SAMPLES = 24,
  parameter int STAB_CYCLES  = 64
) (
  input  logic        clk,
  input  logic        rstPin,
  input  logic        extAccessPin,
  input  logic        lockBit,
  input  lpr_strobe_t strobe,
  output logic        rstQualified,
  output logic        stabDone,
  output logic        intReset,
  output logic        extAccessLatched
);

  localparam int QW = $clog2(QUAL_SAMPLES + 1);
  localparam int SW = (STAB_CYCLES > 2) ? $clog2(STAB_CYCLES) : 1;
  localparam logic [QW-1:0] QUAL_LIMIT = QW'(QUAL_SAMPLES);
  localparam logic [SW-1:0] STAB_LAST  = SW'(STAB_CYCLES - 1);

  logic [QW-1:0] qualCnt;
  logic [SW-1:0] stabCnt;
  logic          eaHold;

  // Consecutive-high sample counter, saturating at the qualification limit
  always_ff @(posedge clk) begin
    if (strobe.qualHold || !rstPin) begin
      qualCnt <= '0;
    end else if (qualCnt < QUAL_LIMIT) begin
      qualCnt <= qualCnt + 1'b1;
    end else begin
      qualCnt <= QUAL_LIMIT;
    end
  end

  assign rstQualified = (qualCnt >= QUAL_LIMIT);

  // Oscillator stabilisation counter
  always_ff @(posedge clk) begin
    if (!strobe.stabRun) begin
      stabCnt <= '0;
    end else if (!stabDone) begin
      stabCnt <= stabCnt + 1'b1;
    end
  end

  assign stabDone = (stabCnt == STAB_LAST);
  assign intReset = rstQualified | strobe.forceRst;

  // External-access level capture during reset (undefined before first reset)
  always_ff @(posedge clk) begin
    if (lockBit && intReset) begin
      eaHold <= extAccessPin;
    end
  end

  assign extAccessLatched = lockBit ? eaHold : extAccessPin;

endmodule

// File: rtl/lpr_ctrl.sv
module lpr_ctrl
  import lpr_pkg::*;
#(
  parameter int IRQ_W = 6
) (
  input  logic             clk,
  input  logic             rstPin,
  input  logic             idleReq,
  input  logic             pdReq,
  input  logic [IRQ_W-1:0] irqVec,
  input  logic             rstQualified,
  input  logic             stabDone,
  input  logic             intReset,
  output lpr_strobe_t      strobe,
  output logic             cpuClkEn,
  output logic             periphClkEn,
  output logic             oscEn,
  output logic             ramInhibit
);

  lpr_mode_t mode;
  lpr_mode_t modeNext;
  logic      anyIrq;

  assign anyIrq = |irqVec;

  always_comb begin
    modeNext = mode;
    if (rstQualified && (mode != MODE_STAB)) begin
      modeNext = MODE_RUN;
    end else begin
      case (mode)
        MODE_RUN: begin
          if (pdReq) begin
            modeNext = MODE_PDOWN;
          end else if (idleReq) begin
            modeNext = MODE_IDLE;
          end
        end
        MODE_IDLE: begin
          if (rstPin) begin
            modeNext = MODE_RSTWIN;
          end else if (anyIrq) begin
            modeNext = MODE_RUN;
          end
        end
        MODE_RSTWIN: begin
          if (!rstPin) begin
            modeNext = MODE_RUN;
          end
        end
        MODE_PDOWN: begin
          if (rstPin) begin
            modeNext = MODE_STAB;
          end
        end
        MODE_STAB: begin
          if (stabDone) begin
            modeNext = MODE_RUN;
          end
        end
        default: modeNext = MODE_RUN;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    mode <= modeNext;
  end

  always_comb begin
    strobe          = '0;
    strobe.qualHold = (mode == MODE_PDOWN);
    strobe.stabRun  = (mode == MODE_STAB);
    strobe.forceRst = (mode == MODE_STAB);
  end

  assign cpuClkEn    = (mode == MODE_RUN) || (mode == MODE_RSTWIN);
  assign periphClkEn = (mode == MODE_RUN) || (mode == MODE_IDLE) || (mode == MODE_RSTWIN);
  assign oscEn       = (mode != MODE_PDOWN);
  assign ramInhibit  = (mode == MODE_RSTWIN) && !intReset;

endmodule

// File: rtl/lowpwr_rst_ctrl.sv
module lowpwr_rst_ctrl
  import lpr_pkg::*;
#(
  parameter int OSC_PER_MCYCLE = 12,
  parameter int RST_MCYCLES    = 2,
  parameter int STAB_CYCLES    = 64,
  parameter int IRQ_W          = 6
) (
  input  logic             clk,
  input  logic             rstPin,
  input  logic             idleReq,
  input  logic             pdReq,
  input  logic [IRQ_W-1:0] irqVec,
  input  logic             extAccessPin,
  input  logic             lockBit,
  output logic             cpuClkEn,
  output logic             periphClkEn,
  output logic             oscEn,
  output logic             intReset,
  output logic             ramInhibit,
  output logic             extAccessLatched
);

  localparam int QUAL_SAMPLES = OSC_PER_MCYCLE * RST_MCYCLES;

  lpr_strobe_t strobe;
  logic        rstQualified;
  logic        stabDone;

  lpr_ctrl #(.IRQ_W(IRQ_W)) u_ctrl (
    .clk          (clk),
    .rstPin       (rstPin),
    .idleReq      (idleReq),
    .pdReq        (pdReq),
    .irqVec       (irqVec),
    .rstQualified (rstQualified),
    .stabDone     (stabDone),
    .intReset     (intReset),
    .strobe       (strobe),
    .cpuClkEn     (cpuClkEn),
    .periphClkEn  (periphClkEn),
    .oscEn        (oscEn),
    .ramInhibit   (ramInhibit)
  );

  lpr_datapath #(
    .QUAL_SAMPLES (QUAL_SAMPLES),
    .STAB_CYCLES  (STAB_CYCLES)
  ) u_dp (
    .clk              (clk),
    .rstPin           (rstPin),
    .extAccessPin     (extAccessPin),
    .lockBit          (lockBit),
    .strobe           (strobe),
    .rstQualified     (rstQualified),
    .stabDone         (stabDone),
    .intReset         (intReset),
    .extAccessLatched (extAccessLatched)
  );

endmodule

// File: rtl/lowpwr_rst_ctrl_checker.sv
module lowpwr_rst_ctrl_checker #(
  parameter int IRQ_W = 6
) (
  input logic             clk,
  input logic             rstPin,
  input logic             idleReq,
  input logic             pdReq,
  input logic [IRQ_W-1:0] irqVec,
  input logic             lockBit,
  input logic             cpuClkEn,
  input logic             periphClkEn,
  input logic             oscEn,
  input logic             intReset,
  input logic             ramInhibit,
  input logic             extAccessLatched
);

  logic sawRst;

  always_ff @(posedge clk) begin
    if (intReset) begin
      sawRst <= 1'b1;
    end
  end

  assert_rst_needs_pin_R1: assert property (@(posedge clk) disable iff (!sawRst)
    $rose(intReset) |-> $past(rstPin));

  assert_rst_release_R1: assert property (@(posedge clk) disable iff (!sawRst)
    (!rstPin && periphClkEn) |=> !intReset);

  assert_idle_entry_R2: assert property (@(posedge clk) disable iff (!sawRst)
    (cpuClkEn && !intReset && !ramInhibit && !rstPin && idleReq && !pdReq) |=>
      (!cpuClkEn && periphClkEn && oscEn));

  assert_idle_exit_R3: assert property (@(posedge clk) disable iff (!sawRst)
    (!cpuClkEn && periphClkEn && (|irqVec)) |=> cpuClkEn);

  assert_pd_entry_R4: assert property (@(posedge clk) disable iff (!sawRst)
    (cpuClkEn && !intReset && !ramInhibit && !rstPin && pdReq) |=> !oscEn);

  assert_pd_all_off_R4: assert property (@(posedge clk) disable iff (!sawRst)
    !oscEn |-> (!cpuClkEn && !periphClkEn));

  assert_pd_irq_ignored_R5: assert property (@(posedge clk) disable iff (!sawRst)
    (!oscEn && !rstPin) |=> !oscEn);

  assert_pd_wake_R6: assert property (@(posedge clk) disable iff (!sawRst)
    (!oscEn && rstPin) |=> (oscEn && intReset && !cpuClkEn && !periphClkEn));

  assert_inhibit_window_R7: assert property (@(posedge clk) disable iff (!sawRst)
    ramInhibit |-> (cpuClkEn && !intReset));

  assert_ea_held_R8: assert property (@(posedge clk) disable iff (!sawRst)
    (lockBit && $past(lockBit) && !$past(intReset)) |-> $stable(extAccessLatched));

  assert_no_sleep_in_reset_R9: assert property (@(posedge clk) disable iff (!sawRst)
    (intReset && periphClkEn) |=> (oscEn && cpuClkEn));

  // Inputs kept visible for the reset-time request check above
  logic unusedReq;
  assign unusedReq = idleReq & pdReq;

endmodule

bind lowpwr_rst_ctrl lowpwr_rst_ctrl_checker #(.IRQ_W(IRQ_W)) u_chk (
  .clk              (clk),
  .rstPin           (rstPin),
  .idleReq          (idleReq),
  .pdReq            (pdReq),
  .irqVec           (irqVec),
  .lockBit          (lockBit),
  .cpuClkEn         (cpuClkEn),
  .periphClkEn      (periphClkEn),
  .oscEn            (oscEn),
  .intReset         (intReset),
  .ramInhibit       (ramInhibit),
  .extAccessLatched (extAccessLatched)
);

// File: tb/lowpwr_rst_ctrl_tb.sv
module lowpwr_rst_ctrl_tb;

  localparam int IRQ_W = 6;
  localparam int STAB  = 40;
  localparam int QUAL  = 24;

  logic             clk = 1'b0;
  logic             rstPin = 1'b0;
  logic             idleReq = 1'b0;
  logic             pdReq = 1'b0;
  logic [IRQ_W-1:0] irqVec = '0;
  logic             extAccessPin = 1'b0;
  logic             lockBit = 1'b0;
  logic             cpuClkEn, periphClkEn, oscEn, intReset, ramInhibit, extAccessLatched;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  lowpwr_rst_ctrl #(.STAB_CYCLES(STAB), .IRQ_W(IRQ_W)) u_dut (
    .clk(clk), .rstPin(rstPin), .idleReq(idleReq), .pdReq(pdReq), .irqVec(irqVec),
    .extAccessPin(extAccessPin), .lockBit(lockBit), .cpuClkEn(cpuClkEn),
    .periphClkEn(periphClkEn), .oscEn(oscEn), .intReset(intReset),
    .ramInhibit(ramInhibit), .extAccessLatched(extAccessLatched)
  );

  always #5 clk = ~clk;

  typedef enum int {M_RUN, M_IDLE, M_PD} bmode_t;

  function automatic logic [2:0] expEn(bmode_t m);
    case (m)
      M_RUN:   return 3'b111;  // {cpu, periph, osc}
      M_IDLE:  return 3'b011;
      default: return 3'b000;
    endcase
  endfunction

  task automatic cyc(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] enVec();
    return {29'd0, cpuClkEn, periphClkEn, oscEn};
  endfunction

  task automatic fullReset();
    rstPin = 1'b1;
    cyc(QUAL + 2);
    rstPin = 1'b0;
    cyc(1);
  endtask

  task automatic enterIdle();
    idleReq = 1'b1;
    cyc(1);
    idleReq = 1'b0;
  endtask

  task automatic wakeFromPd();
    rstPin = 1'b1;
    cyc(1);
    chk("R6 wake osc/reset", {30'd0, oscEn, intReset}, 32'h3);
    rstPin = 1'b0;
    cyc(STAB);
    chk("R6 wake done enables", enVec(), 32'h7);
    chk("R6 wake done reset", {31'd0, intReset}, 32'h0);
  endtask

  initial begin
    bmode_t m;
    void'($urandom(32'd2718));
    cyc(3);

    // Power-on qualification and reset state
    fullReset();
    chk("R1 reset state enables", enVec(), 32'h7);
    chk("R1 reset state intReset", {31'd0, intReset}, 32'h0);
    chk("R7 reset state inhibit", {31'd0, ramInhibit}, 32'h0);

    // R1: 23 samples do not qualify
    rstPin = 1'b1;
    for (int i = 1; i <= QUAL - 1; i++) begin
      cyc(1);
      chk("R1 short pulse no reset", {31'd0, intReset}, 32'h0);
    end
    rstPin = 1'b0;
    cyc(1);
    chk("R1 after 23 samples", {31'd0, intReset}, 32'h0);

    // R1: 24th sample qualifies
    rstPin = 1'b1;
    cyc(QUAL - 1);
    chk("R1 edge 23 no reset", {31'd0, intReset}, 32'h0);
    cyc(1);
    chk("R1 edge 24 reset", {31'd0, intReset}, 32'h1);

    // R9: requests ignored under reset
    pdReq = 1'b1; idleReq = 1'b1;
    cyc(1);
    pdReq = 1'b0; idleReq = 1'b0;
    chk("R9 requests ignored", enVec(), 32'h7);
    cyc(1);
    chk("R9 still running", enVec(), 32'h7);
    rstPin = 1'b0;
    cyc(1);
    chk("R1 release", {31'd0, intReset}, 32'h0);

    // R2 idle entry and hold
    enterIdle();
    chk("R2 idle enables", enVec(), 32'h3);
    cyc(5);
    chk("R2 idle held", enVec(), 32'h3);

    // R3 idle exit
    irqVec = 6'b000100;
    cyc(1);
    irqVec = '0;
    chk("R3 irq wakes", enVec(), 32'h7);

    // R4 power-down priority
    idleReq = 1'b1; pdReq = 1'b1;
    cyc(1);
    idleReq = 1'b0; pdReq = 1'b0;
    chk("R4 pd priority", enVec(), 32'h0);

    // R5 interrupts ignored in power-down
    irqVec = '1;
    for (int i = 0; i < 5; i++) begin
      cyc(1);
      chk("R5 irq ignored", enVec(), 32'h0);
    end
    irqVec = '0;

    // R6 wake with early release
    rstPin = 1'b1;
    cyc(1);
    chk("R6 osc on", {31'd0, oscEn}, 32'h1);
    chk("R6 reset on", {31'd0, intReset}, 32'h1);
    chk("R6 clocks off", {30'd0, cpuClkEn, periphClkEn}, 32'h0);
    cyc(2);
    rstPin = 1'b0;
    for (int i = 4; i <= STAB; i++) begin
      cyc(1);
      chk("R6 reset held", {31'd0, intReset}, 32'h1);
    end
    cyc(1);
    chk("R6 reset end", {31'd0, intReset}, 32'h0);
    chk("R6 run enables", enVec(), 32'h7);

    // R6 wake with pin held beyond stabilisation
    pdReq = 1'b1;
    cyc(1);
    pdReq = 1'b0;
    chk("R4 pd entry", enVec(), 32'h0);
    rstPin = 1'b1;
    cyc(STAB + 10);
    chk("R6 long hold reset", {31'd0, intReset}, 32'h1);
    chk("R6 long hold run", enVec(), 32'h7);
    rstPin = 1'b0;
    cyc(1);
    chk("R6 long hold release", {31'd0, intReset}, 32'h0);

    // R7 reset out of idle
    enterIdle();
    rstPin = 1'b1;
    cyc(1);
    chk("R7 cpu back", {31'd0, cpuClkEn}, 32'h1);
    chk("R7 inhibit on", {31'd0, ramInhibit}, 32'h1);
    for (int i = 2; i <= QUAL - 1; i++) begin
      cyc(1);
      chk("R7 inhibit window", {30'd0, ramInhibit, intReset}, 32'h2);
    end
    cyc(1);
    chk("R7 handover", {30'd0, ramInhibit, intReset}, 32'h1);
    rstPin = 1'b0;
    cyc(1);
    chk("R7 after reset", {29'd0, cpuClkEn, ramInhibit, intReset}, 32'h4);

    // R10 short pulse in idle
    enterIdle();
    rstPin = 1'b1;
    cyc(5);
    chk("R10 inhibit during pulse", {31'd0, ramInhibit}, 32'h1);
    rstPin = 1'b0;
    cyc(1);
    chk("R10 back to run", {29'd0, cpuClkEn, ramInhibit, intReset}, 32'h4);
    cyc(1);
    chk("R10 no late reset", {31'd0, intReset}, 32'h0);

    // R8 external-access latch
    lockBit = 1'b1; extAccessPin = 1'b1;
    fullReset();
    extAccessPin = 1'b0;
    cyc(3);
    chk("R8 latched high", {31'd0, extAccessLatched}, 32'h1);
    lockBit = 1'b0;
    #1;
    chk("R8 unlocked follows pin", {31'd0, extAccessLatched}, 32'h0);
    extAccessPin = 1'b1;
    #1;
    chk("R8 unlocked follows pin high", {31'd0, extAccessLatched}, 32'h1);
    lockBit = 1'b1; extAccessPin = 1'b0;
    fullReset();
    extAccessPin = 1'b1;
    cyc(2);
    chk("R8 latched low", {31'd0, extAccessLatched}, 32'h0);
    lockBit = 1'b0; extAccessPin = 1'b0;

    // Random mode traffic against the bench model (R2 R3 R4 R5)
    m = M_RUN;
    for (int it = 0; it < 400; it++) begin
      logic iq, pq;
      logic [IRQ_W-1:0] iv;
      iq = ($urandom % 6) == 0;
      pq = ($urandom % 15) == 0;
      iv = (($urandom % 5) == 0) ? IRQ_W'($urandom) : '0;
      idleReq = iq; pdReq = pq; irqVec = iv;
      cyc(1);
      idleReq = 1'b0; pdReq = 1'b0; irqVec = '0;
      case (m)
        M_RUN:  m = pq ? M_PD : (iq ? M_IDLE : M_RUN);
        M_IDLE: m = (iv != '0) ? M_RUN : M_IDLE;
        default: m = M_PD;
      endcase
      chk("R2/R3/R4/R5 random mode", enVec(), {29'd0, expEn(m)});
      if (m == M_PD && ($urandom % 3) == 0) begin
        wakeFromPd();
        m = M_RUN;
      end
    end

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog R1 actual=timeout expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule